// File: doc/BRIEF.md
# Floating-Point Exception Status Updater

This block owns a 64-bit floating-point status word and rewrites part of it each time the arithmetic pipeline finishes an operation. A completion arrives as a one-cycle valid strobe carrying the five IEEE exception flags that operation raised. The block compares those flags with the trap-enable mask held in the status word. It then decides whether the operation faults, reduces the reported flags to a single one where required, and rewrites the current-exception field, the accrued-exception field and the trap-type bit.

One cycle after the completion the block pulses one of two outputs. One is a trap request for the sequencer. The other is an advance strobe that tells the sequencer to move PC to next-PC and next-PC to next-PC plus 4. Software may load the whole word through a write port. All other bits of the word are never touched by a completion.

Top module: `fpx_status_upd`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, the status word becomes all zeros and `trap_req` and `pc_adv` are low in the following cycle.
- R2: The flag encoding is invalid=bit 4, overflow=bit 3, underflow=bit 2, divide-by-zero=bit 1 and inexact=bit 0. This order is used on `cmpl_flags` and in all three fields: trap mask at bits 27:23, accrued field at 9:5 and current field at 4:0. A completion whose flags share at least one set bit with the trap mask is a trap. In the cycle after it, `trap_req` is high and status bit 14 is set.
- R3: On a trap, the reported set is the raised flags ANDed with the trap mask. If that set holds two or more bits, a single bit is kept: invalid if present, otherwise divide-by-zero, otherwise inexact. If none of these three is present, the set is left as it is.
- R4: Every completion replaces the current field with the reported set. When there is no trap and overflow or underflow was raised, inexact is also set in that field.
- R5: With no trap, the raised flags are ORed into the accrued field, without the extra inexact bit of R4. On a trap, the accrued field becomes zero.
- R6: A completion without a trap produces a one-cycle `pc_adv` pulse in the following cycle. `trap_req` and `pc_adv` are never high together, and each lasts exactly one cycle.
- R7: A completion with no flags raised clears only the current field and pulses `pc_adv`.
- R8: A cycle with `sw_we` high loads `sw_wdata` into the whole status word. A completion in the same cycle is discarded, and neither pulse follows.
- R9: A completion leaves every status bit outside the current field, the accrued field and bit 14 unchanged. Bit 14 itself is only ever set by a completion, never cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmpl_vld | input | 1 | One-cycle strobe: an operation has completed |
| cmpl_flags | input | 5 | Exception flags raised by that operation |
| sw_we | input | 1 | Software write enable for the whole word |
| sw_wdata | input | 64 | Software write data |
| status_q | output | 64 | Current status word |
| trap_req | output | 1 | One-cycle trap request to the sequencer |
| pc_adv | output | 1 | One-cycle advance strobe to the sequencer |

## Verification
Every result of a completion is due exactly one rising edge after the strobe is sampled. This covers the rewritten status word and the single pulse on `trap_req` or `pc_adv`. The bench drives each stimulus on a falling edge and reads the word and both pulses on the next falling edge, after the one update edge. It then looks one further falling edge later to confirm that the pulse has dropped. A software write, and a reset, are likewise read back one edge after they are driven.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

   localparam int unsigned FLAG_W = 5;

   // Flag positions, shared by the input and all three status fields.
   localparam int unsigned F_INV = 4;
   localparam int unsigned F_OF  = 3;
   localparam int unsigned F_UF  = 2;
   localparam int unsigned F_DZ  = 1;
   localparam int unsigned F_NX  = 0;

   typedef logic [FLAG_W-1:0] flags_t;

   function automatic flags_t flag_bit(input int unsigned idx);
      flags_t v;
      v = '0;
      v[idx] = 1'b1;
      return v;
   endfunction

endpackage

// File: rtl/fpx_trap_pick.sv
module fpx_trap_pick
   import fpx_pkg::*;
#(
   parameter bit FORCE_SINGLE = 1'b0
)(
   input  flags_t raised,
   input  flags_t tmask,
   output logic   trap,
   output flags_t report
);

   flags_t hit;
   flags_t pri3;
   flags_t reduced;
   logic   multi;

   assign hit   = raised & tmask;
   assign trap  = |hit;
   assign multi = (hit & (hit - flags_t'(1))) != '0;

   // Fixed priority among invalid, divide-by-zero and inexact.
   always_comb begin
      pri3 = hit;
      if (multi) begin
         if (hit[F_INV])     pri3 = flag_bit(F_INV);
         else if (hit[F_DZ]) pri3 = flag_bit(F_DZ);
         else if (hit[F_NX]) pri3 = flag_bit(F_NX);
      end
   end

   generate
      if (FORCE_SINGLE) begin : g_force
         // Variant: a remaining overflow+underflow pair collapses to overflow.
         always_comb begin
            reduced = pri3;
            if (pri3[F_OF] && pri3[F_UF]) reduced = flag_bit(F_OF);
         end
      end else begin : g_plain
         always_comb reduced = pri3;
      end
   endgenerate

   assign report = trap ? reduced : raised;

   always_comb begin
      if (trap) begin
         AST_REPORT_SUBSET: assert ((report & ~hit) == '0); // R3
      end
   end

endmodule

// File: rtl/fpx_field_next.sv
module fpx_field_next
   import fpx_pkg::*;
#(
   parameter int unsigned REG_W    = 64,
   parameter int unsigned AEXC_LSB = 5,
   parameter int unsigned CEXC_LSB = 0,
   parameter int unsigned FTT_BIT  = 14
)(
   input  logic [REG_W-1:0] cur,
   input  flags_t           raised,
   input  logic             trap,
   input  flags_t           report,
   output logic [REG_W-1:0] nxt
);

   localparam logic [REG_W-1:0] ONES = REG_W'((1 << FLAG_W) - 1);
   localparam logic [REG_W-1:0] AMSK = ONES << AEXC_LSB;
   localparam logic [REG_W-1:0] CMSK = ONES << CEXC_LSB;

   flags_t cexc_new;
   flags_t aexc_old;
   flags_t aexc_new;

   assign aexc_old = cur[AEXC_LSB +: FLAG_W];

   always_comb begin
      cexc_new = report;
      if (!trap && (report[F_OF] || report[F_UF])) cexc_new[F_NX] = 1'b1;
      aexc_new = trap ? '0 : (aexc_old | raised);
   end

   always_comb begin
      nxt = cur & ~(AMSK | CMSK);
      nxt[CEXC_LSB +: FLAG_W] = cexc_new;
      nxt[AEXC_LSB +: FLAG_W] = aexc_new;
      if (trap) nxt[FTT_BIT] = 1'b1;
   end

endmodule

// File: rtl/fpx_status_upd.sv
module fpx_status_upd
   import fpx_pkg::*;
#(
   parameter int unsigned REG_W        = 64,
   parameter int unsigned TEM_LSB      = 23,
   parameter int unsigned AEXC_LSB     = 5,
   parameter int unsigned CEXC_LSB     = 0,
   parameter int unsigned FTT_BIT      = 14,
   parameter bit          FORCE_SINGLE = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmpl_vld,
   input  logic [4:0]        cmpl_flags,
   input  logic              sw_we,
   input  logic [REG_W-1:0]  sw_wdata,
   output logic [REG_W-1:0]  status_q,
   output logic              trap_req,
   output logic              pc_adv
);

   localparam logic [REG_W-1:0] ONES    = REG_W'((1 << FLAG_W) - 1);
   localparam logic [REG_W-1:0] UPD_MSK = (ONES << AEXC_LSB) | (ONES << CEXC_LSB)
                                          | (REG_W'(1) << FTT_BIT);

   // Elaboration-time parameter checks.
   if (FLAG_W != 5) begin : g_bad_flagw
      $error("flag width must be 5");
   end
   if (TEM_LSB + FLAG_W > REG_W || AEXC_LSB + FLAG_W > REG_W ||
       CEXC_LSB + FLAG_W > REG_W || FTT_BIT >= REG_W) begin : g_bad_range
      $error("status field outside register");
   end
   if ((AEXC_LSB < CEXC_LSB + FLAG_W && CEXC_LSB < AEXC_LSB + FLAG_W) ||
       (TEM_LSB < AEXC_LSB + FLAG_W && AEXC_LSB < TEM_LSB + FLAG_W) ||
       (TEM_LSB < CEXC_LSB + FLAG_W && CEXC_LSB < TEM_LSB + FLAG_W)) begin : g_bad_overlap
      $error("status fields overlap");
   end

   flags_t           tmask;
   logic             trap;
   flags_t           report;
   logic [REG_W-1:0] nxt;
   logic             take;

   assign tmask = status_q[TEM_LSB +: FLAG_W];
   assign take  = cmpl_vld && !sw_we;

   fpx_trap_pick #(.FORCE_SINGLE(FORCE_SINGLE)) u_pick (
      .raised (cmpl_flags),
      .tmask  (tmask),
      .trap   (trap),
      .report (report)
   );

   fpx_field_next #(
      .REG_W    (REG_W),
      .AEXC_LSB (AEXC_LSB),
      .CEXC_LSB (CEXC_LSB),
      .FTT_BIT  (FTT_BIT)
   ) u_next (
      .cur    (status_q),
      .raised (cmpl_flags),
      .trap   (trap),
      .report (report),
      .nxt    (nxt)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         status_q <= '0;
         trap_req <= 1'b0;
         pc_adv   <= 1'b0;
      end else begin
         trap_req <= take && trap;
         pc_adv   <= take && !trap;
         if (sw_we)     status_q <= sw_wdata;
         else if (take) status_q <= nxt;
      end
   end

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(trap_req && pc_adv)); // R6

   AST_TRAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |=> !trap_req); // R6

   AST_ADV_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      pc_adv |=> !pc_adv); // R6

   AST_TRAP_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (status_q[FTT_BIT] && status_q[AEXC_LSB +: FLAG_W] == '0
                    && status_q[CEXC_LSB +: FLAG_W] != '0)); // R2

   AST_ACCRUE_GROW: assert property (@(posedge clk) disable iff (!rst_n)
      pc_adv |-> ((status_q[AEXC_LSB +: FLAG_W] & $past(status_q[AEXC_LSB +: FLAG_W]))
                  == $past(status_q[AEXC_LSB +: FLAG_W]))); // R5

   AST_OTHER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (trap_req || pc_adv) |-> ((status_q & ~UPD_MSK) == ($past(status_q) & ~UPD_MSK))); // R9

   AST_SW_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      $past(sw_we && rst_n) |-> (status_q == $past(sw_wdata) && !trap_req && !pc_adv)); // R8

endmodule

// File: tb/fpx_status_upd_tb.sv
module fpx_status_upd_tb;

   localparam int CLK_PERIOD = 10;
   localparam int NV = 12;

   // {tem, aexc_in, flags, exp_cexc, exp_aexc, exp_trap}
   localparam logic [25:0] VEC [NV] = '{
      {5'h00, 5'h00, 5'h00, 5'h00, 5'h00, 1'b0},  // R7 no flags
      {5'h00, 5'h03, 5'h01, 5'h01, 5'h03, 1'b0},  // R4 R5 inexact only
      {5'h00, 5'h00, 5'h08, 5'h09, 5'h08, 1'b0},  // R4 overflow adds inexact
      {5'h00, 5'h00, 5'h04, 5'h05, 5'h04, 1'b0},  // R4 underflow adds inexact
      {5'h1F, 5'h0A, 5'h12, 5'h10, 5'h00, 1'b1},  // R3 invalid beats dz
      {5'h03, 5'h00, 5'h03, 5'h02, 5'h00, 1'b1},  // R3 dz beats inexact
      {5'h09, 5'h00, 5'h09, 5'h01, 5'h00, 1'b1},  // R3 inexact beats overflow
      {5'h0C, 5'h11, 5'h0C, 5'h0C, 5'h00, 1'b1},  // R3 of+uf pair kept
      {5'h10, 5'h00, 5'h18, 5'h10, 5'h00, 1'b1},  // R2 masked to invalid
      {5'h08, 5'h10, 5'h05, 5'h05, 5'h15, 1'b0},  // R2 no overlap, no trap
      {5'h08, 5'h07, 5'h08, 5'h08, 5'h00, 1'b1},  // R4 trapped overflow, no inexact
      {5'h00, 5'h02, 5'h0C, 5'h0D, 5'h0E, 1'b0}   // R5 accrue without extra inexact
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmpl_vld = 1'b0;
   logic [4:0]  cmpl_flags = '0;
   logic        sw_we = 1'b0;
   logic [63:0] sw_wdata = '0;
   logic [63:0] status_q;
   logic        trap_req;
   logic        pc_adv;

   int n_chk = 0;
   int n_err = 0;
   bit done  = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   fpx_status_upd u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmpl_vld   (cmpl_vld),
      .cmpl_flags (cmpl_flags),
      .sw_we      (sw_we),
      .sw_wdata   (sw_wdata),
      .status_q   (status_q),
      .trap_req   (trap_req),
      .pc_adv     (pc_adv)
   );

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic sw_load(input logic [63:0] v);
      @(negedge clk);
      sw_we = 1'b1; sw_wdata = v;
      @(negedge clk);
      sw_we = 1'b0;
   endtask

   task automatic complete(input logic [4:0] f);
      @(negedge clk);
      cmpl_vld = 1'b1; cmpl_flags = f;
      @(negedge clk);
      cmpl_vld = 1'b0; cmpl_flags = '0;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [63:0] base, exp;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(status_q == 64'd0, "R1 status", status_q, 64'd0);
      chk({trap_req, pc_adv} == 2'b00, "R1 pulses", {62'd0, trap_req, pc_adv}, 64'd0);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [4:0] tem, ain, fl, ec, ea;
         logic       et;
         {tem, ain, fl, ec, ea, et} = VEC[i];
         base = 64'hA5A5_0000_0000_1000 | (64'(tem) << 23) | (64'(ain) << 5) | 64'h1F;
         sw_load(base);
         complete(fl);
         exp = (base & ~64'h3FF) | (64'(ea) << 5) | 64'(ec) | (64'(et) << 14);
         chk(status_q == exp, "R2 R3 R4 R5 R9 status word", status_q, exp);
         chk(trap_req == et && pc_adv == !et, "R2 R6 pulse select",
             {62'd0, trap_req, pc_adv}, {62'd0, et, !et});
         @(negedge clk);
         chk(!trap_req && !pc_adv, "R6 pulse width", {62'd0, trap_req, pc_adv}, 64'd0);
      end

      // R9 bit 14 already set survives an untrapped completion
      sw_load(64'h0000_0000_0000_4000);
      complete(5'h01);
      chk(status_q == 64'h0000_0000_0000_4021, "R9 fault bit held", status_q, 64'h4021);

      // R8 software write wins over a completion in the same cycle
      sw_load(64'h0000_0000_0F80_0000);
      @(negedge clk);
      sw_we = 1'b1; sw_wdata = 64'h1234_5678_0000_0000;
      cmpl_vld = 1'b1; cmpl_flags = 5'h10;
      @(negedge clk);
      sw_we = 1'b0; cmpl_vld = 1'b0; cmpl_flags = '0;
      chk(status_q == 64'h1234_5678_0000_0000, "R8 load", status_q, 64'h1234_5678_0000_0000);
      chk(!trap_req && !pc_adv, "R8 no pulse", {62'd0, trap_req, pc_adv}, 64'd0);

      // R7 zero flags after accrued state: only current field cleared
      sw_load(64'h0000_0000_0000_02FF);
      complete(5'h00);
      chk(status_q == 64'h0000_0000_0000_02E0, "R7 clear current", status_q, 64'h2E0);
      chk(pc_adv && !trap_req, "R7 advance", {62'd0, trap_req, pc_adv}, 64'd1);

      // R1 reset mid-run clears everything
      sw_load(64'hFFFF_FFFF_FFFF_FFFF);
      @(negedge clk);
      rst_n = 1'b0; cmpl_vld = 1'b1; cmpl_flags = 5'h1F;
      @(negedge clk);
      cmpl_vld = 1'b0; cmpl_flags = '0;
      chk(status_q == 64'd0, "R1 mid reset", status_q, 64'd0);
      chk(!trap_req && !pc_adv, "R1 mid reset pulses", {62'd0, trap_req, pc_adv}, 64'd0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule